// File: doc/BRIEF.md
# Four-Way Set-Associative Cache Lookup

This block holds the tag, status and data storage of a four-way set-associative cache, along with its lookup logic. A request address is split into a tag, a set index and a word select. The index picks one set row, and every way of that row has its tag and line read in the same cycle. Each way compares its stored tag against the request tag and uses its own multiplexer to pick the addressed 32-bit word. The word from the hitting way is driven out together with a valid strobe. On a miss the strobe stays low and the data bus stays at zero.

Two ports modify the storage. The fill port writes a whole line into a victim way, marks it valid and clean, and reports whether a valid line was displaced and whether that line was dirty. The victim is the lowest-numbered invalid way of the set. When all four ways are valid, a round-robin pointer kept for each set picks the victim instead. The write port updates one word of a line that is already present and marks that way dirty. Fetching lines from the next memory level is the job of the surrounding controller.

Top module: `sa4_cache_lookup`

## Requirements
- R1: The address splits as follows: bits [OFF_W-1:2] select the word (OFF_W = log2 of the line size in bytes), the next log2(SETS) bits select the set, and the remaining upper bits form the tag. Bits [1:0] are ignored.
- R2: A synchronous active-low reset clears every valid bit, every dirty bit and every round-robin pointer. After reset every read misses, and rd_valid, wr_hit and evict_valid are low.
- R3: A read hits when a way of the indexed set is valid and its tag matches. One cycle after rd_en, rd_valid is high and rd_data holds the addressed word of that way.
- R4: A read that misses leaves rd_valid low and rd_data zero in the following cycle.
- R5: At most one way matches a lookup, given that the same tag is never filled twice into one set.
- R6: A fill writes the whole line (word n in bits [32n+31:32n] of fill_line) into the victim way, sets its valid bit and clears its dirty bit. When the set has an invalid way, the victim is the lowest-numbered invalid way, and fill_way shows it one cycle later.
- R7: When all four ways of the set are valid, the victim is that set's round-robin pointer. The pointer starts at way 0 and advances by one, modulo 4, after each such fill. Fills into a set with an invalid way leave the pointer unchanged.
- R8: One cycle after a fill, evict_valid is high exactly when the victim held a valid line, and evict_dirty then carries that line's dirty bit (otherwise it is low).
- R9: A write whose tag hits updates only the addressed word, sets that way's dirty bit, and raises wr_hit one cycle later. A write that misses changes no state and leaves wr_hit low.
- R10: A write presented in the same cycle as a fill is ignored. wr_hit stays low and no word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Lookup request |
| rd_addr | input | ADDR_W | Lookup byte address |
| rd_valid | output | 1 | Lookup hit strobe, one cycle after rd_en |
| rd_data | output | 32 | Hit word, zero otherwise |
| wr_en | input | 1 | Word write request |
| wr_addr | input | ADDR_W | Word write byte address |
| wr_data | input | 32 | Word write data |
| wr_hit | output | 1 | Write found its line and was applied |
| fill_en | input | 1 | Line fill request |
| fill_addr | input | ADDR_W | Address of the line being filled |
| fill_line | input | 8*LINE_BYTES | Whole line, word 0 in the low bits |
| fill_way | output | 2 | Way chosen by the most recent fill |
| evict_valid | output | 1 | Last fill displaced a valid line |
| evict_dirty | output | 1 | Displaced line was dirty |

## Verification
The one-hot check on the way matches only holds if the caller never fills a tag that is already resident in the set. The bench keeps to this by drawing fill tags from disjoint arithmetic sequences for each set and each refill round. The checks on fill and write after-effects assume the two ports never target the same way in the same cycle, because the block itself lets the fill win. Addresses, line contents and write data are all arithmetic functions of tag, set and word, so any misrouted word shows up as a mismatch.

// File: rtl/sa_cache_pkg.sv
`timescale 1ns/1ps
// Shared constants for the set-associative cache lookup.
// Assumes a fixed four-way organisation and 32-bit words.
package sa_cache_pkg;
    localparam int NUM_WAYS   = 4;
    localparam int WAY_W      = 2;
    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = 4;
endpackage

// File: rtl/cache_way_bank.sv
`timescale 1ns/1ps
// One way of the cache: tag array, valid/dirty status, data array,
// tag comparators for the lookup and write ports, and a per-way word mux.
// Assumes fill_we and word_we are never high together (the top gates this).
module cache_way_bank
    import sa_cache_pkg::*;
#(
    parameter int TAG_W  = 21,
    parameter int IDX_W  = 6,
    parameter int WSEL_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IDX_W-1:0]        lk_idx,
    input  logic [TAG_W-1:0]        lk_tag,
    input  logic [WSEL_W-1:0]       lk_wsel,
    output logic                    lk_hit,
    output logic [WORD_W-1:0]       lk_word,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [TAG_W-1:0]        wr_tag,
    input  logic [WSEL_W-1:0]       wr_wsel,
    input  logic [WORD_W-1:0]       wr_data,
    input  logic                    word_we,
    output logic                    wr_match,
    input  logic [IDX_W-1:0]        fl_idx,
    input  logic [TAG_W-1:0]        fl_tag,
    input  logic [WORD_W*(1<<WSEL_W)-1:0] fl_line,
    input  logic                    fill_we,
    output logic                    fl_valid,
    output logic                    fl_dirty
);
    localparam int SETS = 1 << IDX_W;
    localparam int WPL  = 1 << WSEL_W;

    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [SETS-1:0]   valid_q;
    logic [SETS-1:0]   dirty_q;
    logic [WORD_W-1:0] data_q [SETS][WPL];

    // Status bits: cleared on reset, set clean by a fill, dirtied by a word write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_we) begin
            valid_q[fl_idx] <= 1'b1;
            dirty_q[fl_idx] <= 1'b0;
        end else if (word_we) begin
            dirty_q[wr_idx] <= 1'b1;
        end
    end

    // Tag storage: written only by a fill.
    always_ff @(posedge clk) begin
        if (fill_we) begin
            tag_q[fl_idx] <= fl_tag;
        end
    end

    // Data storage: whole line on fill, single word on write.
    always_ff @(posedge clk) begin
        if (fill_we) begin
            for (int w = 0; w < WPL; w++) begin
                data_q[fl_idx][w] <= fl_line[w*WORD_W +: WORD_W];
            end
        end else if (word_we) begin
            data_q[wr_idx][wr_wsel] <= wr_data;
        end
    end

    // Lookup comparator and per-way word mux, read in parallel.
    always_comb begin
        lk_hit  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        lk_word = data_q[lk_idx][lk_wsel];
    end

    // Write-port comparator and status seen by victim selection.
    always_comb begin
        wr_match = valid_q[wr_idx] && (tag_q[wr_idx] == wr_tag);
        fl_valid = valid_q[fl_idx];
        fl_dirty = dirty_q[fl_idx];
    end

    // R6: a filled row is valid and clean in the next cycle.
    assert_fill_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we |=> (valid_q[$past(fl_idx)] && !dirty_q[$past(fl_idx)]));

    // R9: a word write leaves its row dirty.
    assert_write_dirty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        word_we |=> dirty_q[$past(wr_idx)]);
endmodule

// File: rtl/cache_victim_pick.sv
`timescale 1ns/1ps
// Victim selection for a fill: lowest invalid way, otherwise the per-set
// round-robin pointer, which advances only on fills into a full set.
module cache_victim_pick
    import sa_cache_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fill_en,
    input  logic [IDX_W-1:0]    fill_idx,
    input  logic [NUM_WAYS-1:0] valid_vec,
    output logic [WAY_W-1:0]    victim,
    output logic                set_full
);
    localparam int SETS = 1 << IDX_W;

    logic [WAY_W-1:0] rr_q [SETS];
    logic [WAY_W-1:0] first_free;
    logic [WAY_W-1:0] victim_next;

    // Priority search for the lowest-numbered invalid way.
    always_comb begin
        first_free = '0;
        for (int i = NUM_WAYS - 1; i >= 0; i--) begin
            if (!valid_vec[i]) first_free = WAY_W'(i);
        end
        set_full    = &valid_vec;
        victim      = set_full ? rr_q[fill_idx] : first_free;
        victim_next = victim + 1'b1;
    end

    // Round-robin pointers: reset to way 0, step on each full-set fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
        end else if (fill_en && set_full) begin
            rr_q[fill_idx] <= victim_next;
        end
    end

    // R6: with a free way present, the victim is not a valid way.
    assert_victim_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !set_full) |-> !valid_vec[victim]);

    // R7: after a full-set fill the pointer moves past the chosen victim.
    assert_rr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && set_full) |=> (rr_q[$past(fill_idx)] == $past(victim_next)));
endmodule

// File: rtl/sa4_cache_lookup.sv
`timescale 1ns/1ps
// Four-way set-associative cache lookup with fill and word-write ports.
// Assumes the caller never fills a tag already present in the set; a fill
// takes precedence over a same-cycle write. Outputs are registered.
module sa4_cache_lookup
    import sa_cache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SETS       = 64,
    parameter int LINE_BYTES = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic                    rd_valid,
    output logic [WORD_W-1:0]       rd_data,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [WORD_W-1:0]       wr_data,
    output logic                    wr_hit,
    input  logic                    fill_en,
    input  logic [ADDR_W-1:0]       fill_addr,
    input  logic [8*LINE_BYTES-1:0] fill_line,
    output logic [WAY_W-1:0]        fill_way,
    output logic                    evict_valid,
    output logic                    evict_dirty
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int WSEL_W = OFF_W - $clog2(WORD_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;

    logic [TAG_W-1:0]    rd_tag, wr_tag, fl_tag;
    logic [IDX_W-1:0]    rd_idx, wr_idx, fl_idx;
    logic [WSEL_W-1:0]   rd_wsel, wr_wsel;
    logic [NUM_WAYS-1:0] hit_vec, wmatch_vec, fvalid_vec, fdirty_vec;
    logic [WORD_W-1:0]   word_arr [NUM_WAYS];
    logic [WORD_W-1:0]   sel_word;
    logic [WAY_W-1:0]    victim;
    logic                set_full;
    logic                rd_hit, wr_ok;
    logic                unused_addr_bits;

    // Address field split for the three ports.
    always_comb begin
        rd_tag  = rd_addr[ADDR_W-1 -: TAG_W];
        rd_idx  = rd_addr[OFF_W +: IDX_W];
        rd_wsel = rd_addr[WORD_W/16 +: WSEL_W];
        wr_tag  = wr_addr[ADDR_W-1 -: TAG_W];
        wr_idx  = wr_addr[OFF_W +: IDX_W];
        wr_wsel = wr_addr[WORD_W/16 +: WSEL_W];
        fl_tag  = fill_addr[ADDR_W-1 -: TAG_W];
        fl_idx  = fill_addr[OFF_W +: IDX_W];
    end
    assign unused_addr_bits = ^{rd_addr[1:0], wr_addr[1:0], fill_addr[OFF_W-1:0]};

    // One bank per way, all read in the same cycle.
    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
        cache_way_bank #(.TAG_W(TAG_W), .IDX_W(IDX_W), .WSEL_W(WSEL_W)) i_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .lk_idx   (rd_idx),
            .lk_tag   (rd_tag),
            .lk_wsel  (rd_wsel),
            .lk_hit   (hit_vec[g]),
            .lk_word  (word_arr[g]),
            .wr_idx   (wr_idx),
            .wr_tag   (wr_tag),
            .wr_wsel  (wr_wsel),
            .wr_data  (wr_data),
            .word_we  (wr_en && !fill_en && wmatch_vec[g]),
            .wr_match (wmatch_vec[g]),
            .fl_idx   (fl_idx),
            .fl_tag   (fl_tag),
            .fl_line  (fill_line),
            .fill_we  (fill_en && (victim == WAY_W'(g))),
            .fl_valid (fvalid_vec[g]),
            .fl_dirty (fdirty_vec[g])
        );
    end

    cache_victim_pick #(.IDX_W(IDX_W)) i_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_en   (fill_en),
        .fill_idx  (fl_idx),
        .valid_vec (fvalid_vec),
        .victim    (victim),
        .set_full  (set_full)
    );

    // Hit-gated output select across the four per-way words.
    always_comb begin
        sel_word = '0;
        for (int i = 0; i < NUM_WAYS; i++) begin
            if (hit_vec[i]) sel_word = sel_word | word_arr[i];
        end
        rd_hit = rd_en && (|hit_vec);
        wr_ok  = wr_en && !fill_en && (|wmatch_vec);
    end

    // Registered lookup result, write acknowledge and fill report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid    <= 1'b0;
            rd_data     <= '0;
            wr_hit      <= 1'b0;
            fill_way    <= '0;
            evict_valid <= 1'b0;
            evict_dirty <= 1'b0;
        end else begin
            rd_valid    <= rd_hit;
            rd_data     <= rd_hit ? sel_word : '0;
            wr_hit      <= wr_ok;
            if (fill_en) fill_way <= victim;
            evict_valid <= fill_en && set_full;
            evict_dirty <= fill_en && set_full && fdirty_vec[victim];
        end
    end

    // R5: no two ways match the same lookup.
    assert_single_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec) && $onehot0(wmatch_vec));

    // R3: a hit strobe always answers a request made one cycle earlier.
    assert_valid_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en));

    // R4: the data bus is quiet whenever the strobe is low.
    assert_miss_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));

    // R8: an eviction report follows a fill, and dirty implies valid.
    assert_evict_after_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> ($past(fill_en) && $past(set_full)));
    assert_evict_dirty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evict_dirty |-> evict_valid);

    // R10: no write is acknowledged for a cycle that carried a fill.
    assert_fill_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |-> !$past(fill_en));
endmodule

// File: tb/test_sa4_cache_lookup.sv
`timescale 1ns/1ps
// Bench on a small configuration: 16-bit address, 4 sets, 16-byte lines.
// Address = {tag[9:0], set[1:0], word[1:0], 2'b00}.
module test_sa4_cache_lookup;
    localparam int AW = 16, NS = 4, LB = 16, WPL = 4, NW = 4;

    logic            clk = 1'b0, rst_n = 1'b0;
    logic            rd_en = 1'b0, wr_en = 1'b0, fill_en = 1'b0;
    logic [AW-1:0]   rd_addr = '0, wr_addr = '0, fill_addr = '0;
    logic [31:0]     wr_data = '0;
    logic [8*LB-1:0] fill_line = '0;
    logic            rd_valid, wr_hit, evict_valid, evict_dirty;
    logic [31:0]     rd_data;
    logic [1:0]      fill_way;

    int checks = 0, errors = 0;

    // Reference model
    int          m_tag [NS][NW];
    bit          m_val [NS][NW];
    bit          m_dty [NS][NW];
    logic [31:0] m_dat [NS][NW][WPL];
    int          m_rr  [NS];

    sa4_cache_lookup #(.ADDR_W(AW), .SETS(NS), .LINE_BYTES(LB)) i_sa4_cache_lookup (
        .clk(clk), .rst_n(rst_n),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_hit(wr_hit),
        .fill_en(fill_en), .fill_addr(fill_addr), .fill_line(fill_line),
        .fill_way(fill_way), .evict_valid(evict_valid), .evict_dirty(evict_dirty)
    );

    always #4 clk = ~clk;

    function automatic logic [AW-1:0] mk_addr(int tag, int idx, int w);
        return {tag[9:0], idx[1:0], w[1:0], 2'b00};
    endfunction

    function automatic logic [31:0] pat(int tag, int idx, int w, int salt);
        return 32'h5A00_0000 ^ (tag << 12) ^ (idx << 8) ^ (w << 4) ^ salt;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < NS; s++) begin
            m_rr[s] = 0;
            for (int w = 0; w < NW; w++) begin
                m_val[s][w] = 0; m_dty[s][w] = 0; m_tag[s][w] = -1;
            end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        chk(rd_valid == 0, "R2", "rd_valid after reset", 32'(rd_valid), 0);
        chk(wr_hit == 0, "R2", "wr_hit after reset", 32'(wr_hit), 0);
        chk(evict_valid == 0, "R2", "evict_valid after reset", 32'(evict_valid), 0);
    endtask

    task automatic do_read(int tag, int idx, int w, string req);
        bit          eh = 0;
        logic [31:0] ed = '0;
        for (int k = 0; k < NW; k++)
            if (m_val[idx][k] && m_tag[idx][k] == tag) begin eh = 1; ed = m_dat[idx][k][w]; end
        rd_en = 1'b1; rd_addr = mk_addr(tag, idx, w) | AW'(w & 3);
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
        chk(rd_valid == eh, req, "rd_valid", 32'(rd_valid), 32'(eh));
        chk(rd_data == ed, req, "rd_data", rd_data, ed);
    endtask

    task automatic do_fill(int tag, int idx, int salt, bit with_wr, int wtag, int widx);
        int v = -1;
        bit full = 1;
        bit ed;
        for (int k = NW - 1; k >= 0; k--) if (!m_val[idx][k]) begin v = k; full = 0; end
        if (full) v = m_rr[idx];
        ed = full && m_dty[idx][v];
        for (int w = 0; w < WPL; w++) fill_line[w*32 +: 32] = pat(tag, idx, w, salt);
        fill_en = 1'b1; fill_addr = mk_addr(tag, idx, 0);
        wr_en = with_wr; wr_addr = mk_addr(wtag, widx, 1); wr_data = 32'hDEAD_0000;
        @(posedge clk); @(negedge clk);
        fill_en = 1'b0; wr_en = 1'b0;
        chk(fill_way == 2'(v), full ? "R7" : "R6", "fill_way", 32'(fill_way), 32'(v));
        chk(evict_valid == full, "R8", "evict_valid", 32'(evict_valid), 32'(full));
        chk(evict_dirty == ed, "R8", "evict_dirty", 32'(evict_dirty), 32'(ed));
        if (with_wr) chk(wr_hit == 0, "R10", "wr_hit with fill", 32'(wr_hit), 0);
        m_val[idx][v] = 1; m_dty[idx][v] = 0; m_tag[idx][v] = tag;
        for (int w = 0; w < WPL; w++) m_dat[idx][v][w] = pat(tag, idx, w, salt);
        if (full) m_rr[idx] = (m_rr[idx] + 1) % NW;
    endtask

    task automatic do_write(int tag, int idx, int w, logic [31:0] d);
        int hw = -1;
        for (int k = 0; k < NW; k++) if (m_val[idx][k] && m_tag[idx][k] == tag) hw = k;
        wr_en = 1'b1; wr_addr = mk_addr(tag, idx, w); wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        chk(wr_hit == (hw >= 0), "R9", "wr_hit", 32'(wr_hit), 32'(hw >= 0));
        if (hw >= 0) begin m_dat[idx][hw][w] = d; m_dty[idx][hw] = 1; end
    endtask

    task automatic sweep_reads(string req);
        for (int s = 0; s < NS; s++)
            for (int k = 0; k < NW; k++)
                if (m_val[s][k])
                    for (int w = 0; w < WPL; w++) do_read(m_tag[s][k], s, w, req);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        @(negedge clk);
        do_reset();
        // R2: nothing resident after reset
        for (int s = 0; s < NS; s++) do_read(3 + s * 5, s, s, "R2");
        // R6: fill all ways, lowest free way first
        for (int s = 0; s < NS; s++)
            for (int k = 0; k < NW; k++) do_fill(3 + s * 5 + k * 37, s, 1, 0, 0, 0);
        // R1/R3: every word of every resident line
        sweep_reads("R3");
        // R1/R4: tag of one set looked up in the neighbouring set, and absent tags
        for (int s = 0; s < NS; s++) do_read(3 + s * 5, (s + 1) % NS, 2, "R1");
        for (int s = 0; s < NS; s++) do_read(999, s, 0, "R4");
        // R9: write hits on one way per set, then write misses
        for (int s = 0; s < NS; s++) do_write(3 + s * 5 + s * 37, s, s, 32'hC0DE_0000 + 32'(s));
        for (int s = 0; s < NS; s++) do_write(998, s, 1, 32'hBAD0_0000);
        sweep_reads("R9");
        // R7/R8: refill full sets, round-robin 0,1,2,3,0 with dirty reports
        for (int s = 0; s < NS; s++)
            for (int j = 0; j < 5; j++) do_fill(200 + j * 41 + s * 7, s, 2 + j, 0, 0, 0);
        sweep_reads("R7");
        for (int s = 0; s < NS; s++) do_read(3 + s * 5, s, 0, "R8");
        // R10: a write that would hit is dropped when a fill shares its cycle
        do_fill(500, 2, 9, 1, m_tag[1][0], 1);
        do_read(m_tag[1][0], 1, 1, "R10");
        do_read(500, 2, 3, "R10");
        // R2: second reset clears lines and pointers
        begin
            int old_tag = m_tag[0][1];
            do_reset();
            do_read(old_tag, 0, 0, "R2");
        end
        for (int k = 0; k < 5; k++) do_fill(600 + k * 13, 0, 7, 0, 0, 0);
        sweep_reads("R7");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule